// File: doc/BRIEF.md
# Event Readout Phase Sequencer

This block puts the readout of one event in order. After a level-1 accept it passes through four phases: header, tower data, seed mask and trailer. It then returns to the complete (idle) state. Each phase owns an active-low token. A phase activates the next token when its own end condition is met, and every token already active stays active until the event is complete. The header and trailer phases end on done pulses from their sources. The tower-data phase ends when a programmable number of input strobes has been counted. The seed-mask phase ends after a programmable number of clock cycles.

The output multiplexer has no central controller. Each source select is decoded by watching the token chain: a phase is selected while its own token is active and its successor's token is not. The selected source's data word and valid flag go straight to the output link. A read-only status word shows the five tokens. The number of strobes received in the current or last event can be read back. A level-1 accept that arrives in the middle of an event is dropped and leaves a sticky overrun flag set.

Top module: `readout_token_seq`

## Requirements
- R1: While reset is asserted, and at the first edge after it, `status` is 5'b01111, `src_sel` is 0, `out_valid` is 0, `out_data` is 0, `rx_count` is 0 and `overrun` is 0.
- R2: A `l1_accept` that is sampled while the block is complete activates the header token (status bit 0 low) and deactivates the complete token (status bit 4 high) at the next clock edge.
- R3: A `hdr_done` sampled during the header phase activates the tower-data token (bit 1 low) at the next edge. The header token stays low.
- R4: In the tower-data phase, each cycle with `strobe_in` high adds one to `rx_count`, until `rx_count` equals `exp_words`. Strobes outside this phase, or after the count is reached, are not counted. The seed-mask token (bit 2) goes low at the edge after the cycle in which `rx_count` equals `exp_words`. This means `exp_words`=0 gives a one-cycle data phase. `rx_count` is cleared when an event starts and holds its value after the event ends.
- R5: The seed-mask phase lasts exactly `mask_cycles`+1 clock cycles. After that the trailer token (bit 3) goes low.
- R6: A `trl_done` sampled during the trailer phase returns the block to the complete state at the next edge: status 5'b01111.
- R7: `src_sel` is one-hot or zero. Bit i is high while token i is active (low) and token i+1 is inactive. Index 0 is header, 1 tower data, 2 seed mask, 3 trailer. The token after the trailer is the complete token.
- R8: In the same cycle, `out_data`/`out_valid` equal the data and valid of the selected source. Unselected sources have no effect.
- R9: While the block is complete, `out_valid` is 0 and `out_data` is 0, whatever the sources drive.
- R10: A `l1_accept` sampled while the complete token is inactive does not change the sequence and sets `overrun`. `overrun` then stays 1 until reset.
- R11: `status` bits 0..4 are the header, tower-data, seed-mask, trailer and complete tokens, each active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_accept | input | 1 | Starts an event when the block is complete |
| hdr_done | input | 1 | Header source finished |
| strobe_in | input | 1 | Input data strobe, counted in the tower-data phase |
| trl_done | input | 1 | Trailer source finished |
| exp_words | input | CNT_W (8) | Strobes expected in the tower-data phase |
| mask_cycles | input | MASK_W (8) | Seed-mask phase length minus one, in cycles |
| hdr_data | input | DATA_W (16) | Header source word |
| hdr_valid | input | 1 | Header source valid |
| twr_data | input | DATA_W (16) | Tower-data source word |
| twr_valid | input | 1 | Tower-data source valid |
| msk_data | input | DATA_W (16) | Seed-mask source word |
| msk_valid | input | 1 | Seed-mask source valid |
| trl_data | input | DATA_W (16) | Trailer source word |
| trl_valid | input | 1 | Trailer source valid |
| out_data | output | DATA_W (16) | Output link word |
| out_valid | output | 1 | Output link valid |
| src_sel | output | 4 | Decoded source select |
| status | output | 5 | Token status, active low |
| rx_count | output | CNT_W (8) | Strobes counted in this or the last event |
| overrun | output | 1 | Sticky flag for a dropped level-1 accept |

## Verification
Token changes (R2–R6, R10) take effect one clock edge after the input that causes them is sampled. Inputs are driven just after each falling edge, and status, select and rx_count are read later in that same low half-period, so every check looks at the cycle after the edge that moved the token. The output multiplexer has no register, so a source word reaches the link in the cycle it is driven. The driver pushes each word whose phase should be selected and whose valid is high; the monitor takes words from the link in the same half-period and compares them in order. The bench keeps its own strobe and cycle counters, and from them it knows which cycle is the last one of the data and mask phases.

// File: rtl/rts_pkg.sv
package rts_pkg;

    localparam int NUM_SRC = 4;

    // Token chain, active low. The packed order matches the status word:
    // bit 0 header ... bit 4 complete.
    typedef struct packed {
        logic cmp_n;
        logic trl_n;
        logic msk_n;
        logic dat_n;
        logic hdr_n;
    } token_t;

    localparam token_t TOK_IDLE = '{cmp_n: 1'b0, trl_n: 1'b1, msk_n: 1'b1,
                                    dat_n: 1'b1, hdr_n: 1'b1};

    // A select is high when its own token is active and the next one is not.
    function automatic logic [NUM_SRC-1:0] spy_select(token_t t);
        logic [NUM_SRC:0] chain;
        logic [NUM_SRC-1:0] s;
        chain = t;
        for (int i = 0; i < NUM_SRC; i++)
            s[i] = !chain[i] && chain[i+1];
        return s;
    endfunction

endpackage

// File: rtl/rts_limit_counter.sv
module rts_limit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);
    assign hit = (count == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (step && !hit)
            count <= count + 1'b1;
    end

    // Counter never runs past its limit
    no_pass_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/rts_token_chain.sv
module rts_token_chain
    import rts_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l1_accept,
    input  logic              hdr_done,
    input  logic              strobe_in,
    input  logic              trl_done,
    input  logic [CNT_W-1:0]  exp_words,
    input  logic [MASK_W-1:0] mask_cycles,
    output token_t            tok,
    output logic [CNT_W-1:0]  rx_count,
    output logic              overrun
);
    logic [NUM_SRC-1:0] phase;
    logic idle, start, in_hdr, in_dat, in_msk, in_trl;
    logic dat_hit, msk_hit;
    logic [MASK_W-1:0] msk_count;

    assign phase  = spy_select(tok);
    assign in_hdr = phase[0];
    assign in_dat = phase[1];
    assign in_msk = phase[2];
    assign in_trl = phase[3];
    assign idle   = !tok.cmp_n;
    assign start  = idle && l1_accept;

    rts_limit_counter #(.W(CNT_W)) u_dat_cnt (
        .clk(clk), .rst(rst), .clr(start), .step(in_dat && strobe_in),
        .limit(exp_words), .count(rx_count), .hit(dat_hit)
    );

    rts_limit_counter #(.W(MASK_W)) u_msk_cnt (
        .clk(clk), .rst(rst), .clr(!in_msk), .step(in_msk),
        .limit(mask_cycles), .count(msk_count), .hit(msk_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tok     <= TOK_IDLE;
            overrun <= 1'b0;
        end else begin
            if (l1_accept && !idle)
                overrun <= 1'b1;
            if (start) begin
                tok.hdr_n <= 1'b0;
                tok.cmp_n <= 1'b1;
            end
            if (in_hdr && hdr_done)
                tok.dat_n <= 1'b0;
            if (in_dat && dat_hit)
                tok.msk_n <= 1'b0;
            if (in_msk && msk_hit)
                tok.trl_n <= 1'b0;
            if (in_trl && trl_done)
                tok <= TOK_IDLE;
        end
    end

    // R2
    start_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && l1_accept) |=> (!tok.hdr_n && tok.cmp_n));
    // R4
    data_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_dat && rx_count == exp_words) |=> !tok.msk_n);
    // R6
    trl_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_trl && trl_done) |=> (tok == TOK_IDLE));
    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    // R10
    busy_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && l1_accept) |=> overrun);
endmodule

// File: rtl/rts_src_mux.sv
module rts_src_mux #(
    parameter int NSRC = 4,
    parameter int DW   = 16
) (
    input  logic [NSRC-1:0] sel,
    input  logic [DW-1:0]   src_data [NSRC],
    input  logic [NSRC-1:0] src_valid,
    output logic [DW-1:0]   out_data,
    output logic            out_valid
);
    logic [DW-1:0] gated [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = sel[g] ? src_data[g] : '0;
    end

    always_comb begin
        out_data = '0;
        for (int i = 0; i < NSRC; i++)
            out_data = out_data | gated[i];
    end

    assign out_valid = |(sel & src_valid);

    // R7
    sel_onehot_chk: assert final ($onehot0(sel));
endmodule

// File: rtl/readout_token_seq.sv
module readout_token_seq
    import rts_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l1_accept,
    input  logic              hdr_done,
    input  logic              strobe_in,
    input  logic              trl_done,
    input  logic [CNT_W-1:0]  exp_words,
    input  logic [MASK_W-1:0] mask_cycles,
    input  logic [DATA_W-1:0] hdr_data,
    input  logic              hdr_valid,
    input  logic [DATA_W-1:0] twr_data,
    input  logic              twr_valid,
    input  logic [DATA_W-1:0] msk_data,
    input  logic              msk_valid,
    input  logic [DATA_W-1:0] trl_data,
    input  logic              trl_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [NUM_SRC-1:0] src_sel,
    output logic [4:0]        status,
    output logic [CNT_W-1:0]  rx_count,
    output logic              overrun
);
    token_t tok;
    logic [DATA_W-1:0] src_d [NUM_SRC];

    rts_token_chain #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_chain (
        .clk(clk), .rst(rst), .l1_accept(l1_accept), .hdr_done(hdr_done),
        .strobe_in(strobe_in), .trl_done(trl_done), .exp_words(exp_words),
        .mask_cycles(mask_cycles), .tok(tok), .rx_count(rx_count),
        .overrun(overrun)
    );

    assign src_sel = spy_select(tok);
    assign status  = tok;

    assign src_d[0] = hdr_data;
    assign src_d[1] = twr_data;
    assign src_d[2] = msk_data;
    assign src_d[3] = trl_data;

    rts_src_mux #(.NSRC(NUM_SRC), .DW(DATA_W)) u_mux (
        .sel(src_sel), .src_data(src_d),
        .src_valid({trl_valid, msk_valid, twr_valid, hdr_valid}),
        .out_data(out_data), .out_valid(out_valid)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !status[4] |-> (!out_valid && out_data == '0));
endmodule

// File: tb/sim_readout_token_seq.sv
module sim_readout_token_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l1_accept = 0, hdr_done = 0, strobe_in = 0, trl_done = 0;
    logic [7:0] exp_words = 0, mask_cycles = 0;
    logic [15:0] hdr_data = 0, twr_data = 0, msk_data = 0, trl_data = 0;
    logic hdr_valid = 0, twr_valid = 0, msk_valid = 0, trl_valid = 0;
    logic [15:0] out_data;
    logic out_valid, overrun;
    logic [3:0] src_sel;
    logic [4:0] status;
    logic [7:0] rx_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] sb [$];

    always #5 clk = ~clk;

    readout_token_seq u0 (
        .clk(clk), .rst(rst), .l1_accept(l1_accept), .hdr_done(hdr_done),
        .strobe_in(strobe_in), .trl_done(trl_done), .exp_words(exp_words),
        .mask_cycles(mask_cycles), .hdr_data(hdr_data), .hdr_valid(hdr_valid),
        .twr_data(twr_data), .twr_valid(twr_valid), .msk_data(msk_data),
        .msk_valid(msk_valid), .trl_data(trl_data), .trl_valid(trl_valid),
        .out_data(out_data), .out_valid(out_valid), .src_sel(src_sel),
        .status(status), .rx_count(rx_count), .overrun(overrun)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Every source drives a valid word; only the selected one may pass (R8)
    task automatic drive_all(input logic [15:0] tag);
        hdr_data = 16'h1000 | tag; hdr_valid = 1;
        twr_data = 16'h2000 | tag; twr_valid = 1;
        msk_data = 16'h3000 | tag; msk_valid = 1;
        trl_data = 16'h4000 | tag; trl_valid = 1;
    endtask

    task automatic run_event(input int nh, input int ne, input int nm,
                             input int nt, input logic inject);
        int cnt;
        int k;
        exp_words = 8'(ne);
        mask_cycles = 8'(nm);
        @(negedge clk); #1;
        drive_all(16'h0EE);
        l1_accept = 1;
        #2;
        // R9 idle keeps link quiet, R11 idle status
        chk(out_valid == 0 && out_data == 0, "R9", out_data, 0);
        chk(status == 5'b01111, "R11", status, 5'b01111);
        for (int i = 0; i < nh; i++) begin
            @(negedge clk); #1;
            l1_accept = 0;
            drive_all(16'(i));
            hdr_done = (i == nh - 1);
            sb.push_back(16'h1000 | 16'(i));
            #2;
            chk(status == 5'b11110, "R2", status, 5'b11110);
            chk(src_sel == 4'b0001, "R7", src_sel, 4'b0001);
            if (i == 0) chk(rx_count == 0, "R4", rx_count, 0);
        end
        cnt = 0;
        k = 0;
        forever begin
            @(negedge clk); #1;
            hdr_done = 0;
            drive_all(16'(k));
            twr_valid = (k != 2);
            strobe_in = (k % 2 == 0);
            l1_accept = inject && (k == 1);
            if (twr_valid) sb.push_back(16'h2000 | 16'(k));
            #2;
            chk(status == 5'b11100, "R3", status, 5'b11100);
            chk(src_sel == 4'b0010, "R7", src_sel, 4'b0010);
            chk(rx_count == 8'(cnt), "R4", rx_count, cnt);
            if (cnt == ne) break;
            if (strobe_in) cnt++;
            k++;
        end
        for (int j = 0; j <= nm; j++) begin
            @(negedge clk); #1;
            l1_accept = 0;
            drive_all(16'(j));
            strobe_in = 1;
            sb.push_back(16'h3000 | 16'(j));
            #2;
            chk(status == 5'b11000, "R5", status, 5'b11000);
            chk(src_sel == 4'b0100, "R7", src_sel, 4'b0100);
        end
        for (int j = 0; j < nt; j++) begin
            @(negedge clk); #1;
            strobe_in = 0;
            drive_all(16'(j));
            trl_done = (j == nt - 1);
            sb.push_back(16'h4000 | 16'(j));
            #2;
            chk(status == 5'b10000, "R5", status, 5'b10000);
            chk(src_sel == 4'b1000, "R7", src_sel, 4'b1000);
        end
        @(negedge clk); #1;
        trl_done = 0;
        strobe_in = 1;
        drive_all(16'h0FF);
        #2;
        chk(status == 5'b01111, "R6", status, 5'b01111);
        chk(src_sel == 4'b0000, "R7", src_sel, 0);
        chk(out_valid == 0 && out_data == 0, "R9", out_data, 0);
        chk(rx_count == 8'(ne), "R4", rx_count, ne);
    endtask

    // Monitor: pops the scoreboard as words leave the link (R8)
    initial begin
        forever begin
            @(negedge clk); #3;
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R8", out_data, 0);
                end else begin
                    logic [15:0] e;
                    e = sb.pop_front();
                    chk(out_data == e, "R8", out_data, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive_all(16'h055);
        repeat (3) @(negedge clk);
        #3;
        // R1 during reset
        chk(status == 5'b01111 && src_sel == 0 && out_valid == 0 && out_data == 0,
            "R1", status, 5'b01111);
        @(negedge clk); #1;
        rst = 0;
        #2;
        chk(rx_count == 0 && overrun == 0, "R1", {rx_count, overrun}, 0);
        run_event(3, 5, 2, 2, 1'b0);
        chk(overrun == 0, "R10", overrun, 0);
        run_event(1, 0, 0, 1, 1'b0);
        run_event(2, 3, 4, 3, 1'b1);
        // R10 dropped accept sets the flag, sequence already checked above
        chk(overrun == 1, "R10", overrun, 1);
        @(negedge clk); #3;
        chk(overrun == 1, "R10", overrun, 1);
        chk(sb.size() == 0, "R8", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule